// File: doc/BRIEF.md
# Three-Pair Complementary PWM Generator

This block drives a three-phase power bridge with six PWM outputs, organised as three high/low channel pairs. One shared period counter runs in either edge-aligned (sawtooth) or center-aligned (up/down) mode. Its clock comes from the core clock through a power-of-two prescaler. Each pair compares the counter with its own duty value to form a reference waveform. The high channel follows that reference and the low channel follows its inverse, with a programmable number of dead cycles before either channel switches on.

Software programs the block through a small write-only register port. Period, dead time and the three duty values are written into shadow copies. These copies move into the active registers only at the end of a PWM cycle, and only when a load-ok flag has been armed. The load-ok flag then clears itself, so a full set of values always changes together. An option routes a write of the first duty register to all three duty shadows. A one-cycle reload pulse marks each cycle boundary and can also latch an interrupt flag. Masking, overrides and fault handling are left to a later stage.

Register map (address on `wr_addr`): 0, 1 and 2 are the duty shadows of pairs 0, 1 and 2. 3 is the period shadow and 4 the dead-time shadow. 5 is control, which takes effect immediately: bit 0 selects center-aligned, bit 1 runs the generator, bit 2 enables the interrupt, bit 3 is the duty broadcast option and bits 6:4 hold the prescaler select. Writing 1 in bit 0 at address 6 arms load-ok. Writing 1 in bit 0 at address 7 clears the interrupt flag.

Top module: `cpwm3_top`

## Requirements
- R1: While reset is asserted and directly after it, all six channel outputs, the reload pulse and the interrupt flag are low.
- R2: Writes to the duty, period and dead-time addresses (0 to 4) change only shadow copies. These are copied to the active set at a reload event only while load-ok is armed (address 6, bit 0), and each such reload clears load-ok.
- R3: With control bit 3 set, a write to address 0 loads the same value into all three duty shadows.
- R4: In edge-aligned mode (control bit 0 = 0), with period P (P = 0 behaves as 1), the counter runs 0 to P-1 and the pair reference is high while counter < duty. Duty 0 gives a reference that is always low, and duty >= P gives one that is always high.
- R5: In center-aligned mode (control bit 0 = 1), the counter climbs 0..P-1, then descends P-1..0, so the cycle lasts 2P ticks and the reference is high for 2*duty ticks per cycle.
- R6: Channel 2k is the pair-k high side and follows the reference. Channel 2k+1 is the low side and follows its inverse. The two channels of a pair are never high together.
- R7: A channel rises only after both channels of its pair have been low for the active dead-time count of clock cycles. A dead time of 0 allows the switch-over on a single edge. A channel switches off without delay.
- R8: The reload output pulses for one clock cycle once per PWM cycle, in the first cycle of the new period.
- R9: With control bit 2 set, each reload event sets the interrupt flag. A write of 1 to address 7, bit 0, clears it. With bit 2 clear, reloads leave the flag low.
- R10: With the run bit (control bit 1) clear, the counter stops, no reload pulses occur, and all outputs go low one cycle later.
- R11: A prescaler select of s advances the counter once every 2^s clock cycles, and s = 0 runs it at the core clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Register write data |
| ch_o | output | 6 | Raw channel outputs, even = high side, odd = low side |
| reload_o | output | 1 | One-cycle reload event pulse |
| irq_o | output | 1 | Reload interrupt flag |

## Verification
A register write lands in the cycle after its strobe edge. The reload pulse and the interrupt flag rise on the same edge at which the counter wraps. Channel outputs lag the counter by one register stage, plus the dead cycles. For this reason the bench never checks a single edge of the waveform. After each reconfiguration it waits for three reload pulses, so that armed values are loaded and the channels have settled. It then counts high cycles and reload pulses over a window of exactly four PWM cycles, which makes the totals independent of phase. The interrupt and shutdown checks are sampled at the falling edge that follows the reload pulse or the write that causes them.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int NPAIR = 3;
  localparam int PRE_W = 3;

  localparam logic [2:0] ADDR_DUTY0  = 3'd0;
  localparam logic [2:0] ADDR_DUTY1  = 3'd1;
  localparam logic [2:0] ADDR_DUTY2  = 3'd2;
  localparam logic [2:0] ADDR_PERIOD = 3'd3;
  localparam logic [2:0] ADDR_DEAD   = 3'd4;
  localparam logic [2:0] ADDR_CTRL   = 3'd5;
  localparam logic [2:0] ADDR_LOAD   = 3'd6;
  localparam logic [2:0] ADDR_ACK    = 3'd7;

  typedef struct packed {
    logic [PRE_W-1:0] presc;
    logic             bcast;
    logic             irq_en;
    logic             run;
    logic             center;
  } ctrl_t;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int CW  = 12,
  parameter int DTW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [2:0]                wr_addr,
  input  logic [CW-1:0]             wr_data,
  input  logic                      reload_i,
  output ctrl_t                     ctrl_o,
  output logic [NPAIR-1:0][CW-1:0]  duty_o,
  output logic [CW-1:0]             period_o,
  output logic [DTW-1:0]            dead_o
);
  ctrl_t                     ctrl_q, ctrl_n;
  logic [NPAIR-1:0][CW-1:0]  sh_duty_q, sh_duty_n, act_duty_q, act_duty_n;
  logic [CW-1:0]             sh_per_q, sh_per_n, act_per_q, act_per_n;
  logic [DTW-1:0]            sh_dt_q, sh_dt_n, act_dt_q, act_dt_n;
  logic                      ldok_q, ldok_n, ldok_set;

  assign ldok_set = wr_en && (wr_addr == ADDR_LOAD) && wr_data[0];

  always_comb begin
    ctrl_n    = ctrl_q;
    sh_duty_n = sh_duty_q;
    sh_per_n  = sh_per_q;
    sh_dt_n   = sh_dt_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_DUTY0: begin
          if (ctrl_q.bcast) begin
            for (int k = 0; k < NPAIR; k++) sh_duty_n[k] = wr_data;
          end else begin
            sh_duty_n[0] = wr_data;
          end
        end
        ADDR_DUTY1:  sh_duty_n[1] = wr_data;
        ADDR_DUTY2:  sh_duty_n[2] = wr_data;
        ADDR_PERIOD: sh_per_n     = wr_data;
        ADDR_DEAD:   sh_dt_n      = wr_data[DTW-1:0];
        ADDR_CTRL:   ctrl_n       = wr_data[$bits(ctrl_t)-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    act_duty_n = act_duty_q;
    act_per_n  = act_per_q;
    act_dt_n   = act_dt_q;
    ldok_n     = ldok_q;
    if (reload_i) begin
      if (ldok_q) begin
        act_duty_n = sh_duty_q;
        act_per_n  = sh_per_q;
        act_dt_n   = sh_dt_q;
      end
      ldok_n = 1'b0;
    end
    if (ldok_set) ldok_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      sh_duty_q  <= '0;
      sh_per_q   <= '0;
      sh_dt_q    <= '0;
      act_duty_q <= '0;
      act_per_q  <= '0;
      act_dt_q   <= '0;
      ldok_q     <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_n;
      sh_duty_q  <= sh_duty_n;
      sh_per_q   <= sh_per_n;
      sh_dt_q    <= sh_dt_n;
      act_duty_q <= act_duty_n;
      act_per_q  <= act_per_n;
      act_dt_q   <= act_dt_n;
      ldok_q     <= ldok_n;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign duty_o   = act_duty_q;
  assign period_o = act_per_q;
  assign dead_o   = act_dt_q;

  // R2: a reload consumes load-ok unless software re-arms it in the same cycle
  p_ldok_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i && !ldok_set) |=> !ldok_q);

  // R2: active values move only on a reload with load-ok armed
  p_act_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reload_i && ldok_q) |=> $stable(act_per_q) && $stable(act_duty_q));
endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
  import cpwm_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             center,
  input  logic [PRE_W-1:0] presc,
  input  logic [CW-1:0]    period,
  output logic [CW-1:0]    cnt_o,
  output logic             wrap_o
);
  localparam int PCW = (1 << PRE_W) - 1;

  logic [PCW-1:0] pre_q, pre_n, mask;
  logic [CW-1:0]  cnt_q, cnt_n, pmax;
  logic           dir_q, dir_n, tick, at_end;

  assign mask   = ~({PCW{1'b1}} << presc);
  assign tick   = run && (&(pre_q | ~mask));
  assign pmax   = (period == '0) ? '0 : period - 1'b1;
  assign at_end = center ? (dir_q && (cnt_q == '0)) : (cnt_q >= pmax);
  assign wrap_o = tick && at_end;

  always_comb begin
    pre_n = run ? pre_q + 1'b1 : '0;
    cnt_n = cnt_q;
    dir_n = dir_q;
    if (!run) begin
      cnt_n = '0;
      dir_n = 1'b0;
    end else if (tick) begin
      if (at_end) begin
        cnt_n = '0;
        dir_n = 1'b0;
      end else if (!center) begin
        cnt_n = cnt_q + 1'b1;
      end else if (!dir_q) begin
        if (cnt_q >= pmax) dir_n = 1'b1;
        else               cnt_n = cnt_q + 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      pre_q <= pre_n;
      cnt_q <= cnt_n;
      dir_q <= dir_n;
    end
  end

  assign cnt_o = cnt_q;

  // R4: the counter never passes the last count of the active period
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= pmax);

  // R8: every cycle boundary restarts the counter from zero counting up
  p_wrap_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0) && !dir_q);

  // R10: a stopped generator holds the counter at zero
  p_stop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           ref_i,
  input  logic [DTW-1:0] dt_i,
  output logic           hi_o,
  output logic           lo_o
);
  logic           hi_q, hi_n, lo_q, lo_n, want_hi, want_lo;
  logic [DTW-1:0] gap_q, gap_n;

  assign want_hi = run && ref_i;
  assign want_lo = run && !ref_i;

  always_comb begin
    hi_n = 1'b0;
    lo_n = 1'b0;
    if (want_hi) begin
      hi_n = hi_q || (dt_i == '0) || (!lo_q && (gap_q >= dt_i));
    end else if (want_lo) begin
      lo_n = lo_q || (dt_i == '0) || (!hi_q && (gap_q >= dt_i));
    end
    if (hi_n || lo_n)        gap_n = '0;
    else if (gap_q == '1)    gap_n = gap_q;
    else                     gap_n = gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      gap_q <= '0;
    end else begin
      hi_q  <= hi_n;
      lo_q  <= lo_n;
      gap_q <= gap_n;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // R6: the two sides of a pair never conduct together
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_q && lo_q));

  // R7: with a nonzero dead time a side rises only after the other was low
  p_dead_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q && !$past(hi_q) && ($past(dt_i) != '0)) |-> !$past(lo_q));

  p_dead_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q && !$past(lo_q) && ($past(dt_i) != '0)) |-> !$past(hi_q));
endmodule

// File: rtl/cpwm3_top.sv
module cpwm3_top
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [5:0]       ch_o,
  output logic             reload_o,
  output logic             irq_o
);
  ctrl_t                       ctrl;
  logic [NPAIR-1:0][CNT_W-1:0] duty;
  logic [CNT_W-1:0]            period, cnt;
  logic [DT_W-1:0]             dead;
  logic                        wrap, ack, irq_q, irq_n, rld_q;
  logic [NPAIR-1:0]            pair_ref;

  cpwm_regs #(.CW(CNT_W), .DTW(DT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .reload_i(wrap), .ctrl_o(ctrl), .duty_o(duty),
    .period_o(period), .dead_o(dead)
  );

  cpwm_timebase #(.CW(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .center(ctrl.center),
    .presc(ctrl.presc), .period(period), .cnt_o(cnt), .wrap_o(wrap)
  );

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    assign pair_ref[k] = (cnt < duty[k]);
    cpwm_deadband #(.DTW(DT_W)) u_db (
      .clk(clk), .rst_n(rst_n), .run(ctrl.run), .ref_i(pair_ref[k]),
      .dt_i(dead), .hi_o(ch_o[2*k]), .lo_o(ch_o[2*k+1])
    );
  end

  assign ack = wr_en && (wr_addr == ADDR_ACK) && wr_data[0];

  always_comb begin
    irq_n = irq_q;
    if (ack)                  irq_n = 1'b0;
    if (wrap && ctrl.irq_en)  irq_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      rld_q <= 1'b0;
    end else begin
      irq_q <= irq_n;
      rld_q <= wrap;
    end
  end

  assign irq_o    = irq_q;
  assign reload_o = rld_q;

  // R9: an enabled reload raises the interrupt flag
  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && ctrl.irq_en) |=> irq_o);

  // R9: with interrupts disabled the flag cannot rise
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !ctrl.irq_en) |=> !irq_o);

  // R10: a stopped generator drives all channels low on the next edge
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run |=> (ch_o == '0) && !reload_o);
endmodule

// File: tb/tb_cpwm3_top.sv
module tb_cpwm3_top;
  localparam int CW  = 12;
  localparam int DTW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [2:0]    wr_addr;
  logic [CW-1:0] wr_data;
  logic [5:0]    ch;
  logic          reload, irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cpwm3_top #(.CNT_W(CW), .DT_W(DTW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ch_o(ch), .reload_o(reload), .irq_o(irq)
  );

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = CW'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic int ctrl_word(int center, int run, int irqen, int bcast, int presc);
    return (presc << 4) | (bcast << 3) | (irqen << 2) | (run << 1) | center;
  endfunction

  function automatic int plen_of(int center, int presc, int p);
    int pe = (p == 0) ? 1 : p;
    return (center ? 2 : 1) * pe * (1 << presc);
  endfunction

  function automatic int exp_hi(int center, int presc, int p, int d, int dt);
    int pl = plen_of(center, presc, p);
    if (d == 0) return 0;
    if (d >= p) return pl;
    return (center ? 2 : 1) * d * (1 << presc) - dt;
  endfunction

  function automatic int exp_lo(int center, int presc, int p, int d, int dt);
    int pl = plen_of(center, presc, p);
    if (d == 0) return pl;
    if (d >= p) return 0;
    return pl - (center ? 2 : 1) * d * (1 << presc) - dt;
  endfunction

  task automatic wait_rl(int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (reload) seen++;
    end
  endtask

  task automatic measure(int ncyc, output int hi[3], output int lo[3],
                         output int rl, output int ov);
    for (int k = 0; k < 3; k++) begin hi[k] = 0; lo[k] = 0; end
    rl = 0; ov = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        if (ch[2*k])   hi[k]++;
        if (ch[2*k+1]) lo[k]++;
        if (ch[2*k] && ch[2*k+1]) ov++;
      end
      if (reload) rl++;
    end
  endtask

  task automatic setup(int center, int presc, int p, int d0, int d1, int d2,
                       int dt, int irqen);
    wr(3'd5, ctrl_word(center, 1, irqen, 0, presc));
    wr(3'd3, p);
    wr(3'd0, d0);
    wr(3'd1, d1);
    wr(3'd2, d2);
    wr(3'd4, dt);
    wr(3'd6, 1);
  endtask

  task automatic verify(string tag, int center, int presc, int p, int d0,
                        int d1, int d2, int dt);
    int hi[3], lo[3], rl, ov, d[3], pl;
    d[0] = d0; d[1] = d1; d[2] = d2;
    pl = plen_of(center, presc, p);
    wait_rl(3);
    measure(4 * pl, hi, lo, rl, ov);
    for (int k = 0; k < 3; k++) begin
      check_eq($sformatf("%s high side pair %0d", tag, k), hi[k],
               4 * exp_hi(center, presc, p, d[k], dt));
      check_eq($sformatf("%s low side pair %0d", tag, k), lo[k],
               4 * exp_lo(center, presc, p, d[k], dt));
    end
    check_eq({tag, " R8 reload count"}, rl, 4);
    check_eq({tag, " R6 overlap cycles"}, ov, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int hi[3], lo[3], rl, ov, seed;
    int p, pr, cen, dt, dsel[3];
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    check_eq("R1 outputs in reset", {26'd0, ch}, 0);
    check_eq("R1 reload and irq in reset", {30'd0, reload, irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R1 outputs after reset", {24'd0, ch, reload, irq}, 0);

    // R10: generator not yet running
    measure(40, hi, lo, rl, ov);
    check_eq("R10 idle channel cycles", hi[0]+hi[1]+hi[2]+lo[0]+lo[1]+lo[2], 0);
    check_eq("R10 idle reloads", rl, 0);

    setup(0, 0, 10, 3, 0, 10, 0, 0);
    verify("R4 R6 edge zero/full", 0, 0, 10, 3, 0, 10, 0);
    setup(0, 0, 10, 4, 5, 6, 2, 0);
    verify("R7 dead time 2", 0, 0, 10, 4, 5, 6, 2);
    setup(1, 0, 10, 3, 7, 0, 1, 0);
    verify("R5 center", 1, 0, 10, 3, 7, 0, 1);
    setup(0, 2, 8, 2, 5, 8, 1, 0);
    verify("R11 prescale 4", 0, 2, 8, 2, 5, 8, 1);
    setup(0, 0, 10, 3, 3, 3, 0, 0);
    verify("R11 prescale 1", 0, 0, 10, 3, 3, 3, 0);

    // R2: shadow writes without load-ok do nothing; load-ok self clears
    wr(3'd0, 6);
    verify("R2 shadow held", 0, 0, 10, 3, 3, 3, 0);
    wr(3'd6, 1);
    verify("R2 armed load", 0, 0, 10, 6, 3, 3, 0);
    wr(3'd0, 8);
    verify("R2 load-ok cleared", 0, 0, 10, 6, 3, 3, 0);

    // R3: broadcast write of the first duty register
    wr(3'd5, ctrl_word(0, 1, 0, 1, 0));
    wr(3'd0, 7);
    wr(3'd6, 1);
    verify("R3 broadcast", 0, 0, 10, 7, 7, 7, 0);

    // R9: interrupt flag
    setup(0, 0, 12, 5, 5, 5, 0, 1);
    wait_rl(2);
    check_eq("R9 flag set by reload", {31'd0, irq}, 1);
    wr(3'd5, ctrl_word(0, 1, 0, 0, 0));
    wr(3'd7, 1);
    check_eq("R9 flag cleared", {31'd0, irq}, 0);
    wait_rl(2);
    check_eq("R9 disabled stays low", {31'd0, irq}, 0);
    wr(3'd5, ctrl_word(0, 1, 1, 0, 0));
    wait_rl(1);
    check_eq("R9 re-enabled set", {31'd0, irq}, 1);

    // Constrained random configurations (R4 R5 R7 R11)
    for (int it = 0; it < 12; it++) begin
      p   = 6 + int'($urandom % 25);
      pr  = int'($urandom % 3);
      cen = int'($urandom % 2);
      dt  = int'($urandom % 3);
      for (int k = 0; k < 3; k++) begin
        case ($urandom % 4)
          0: dsel[k] = 0;
          1: dsel[k] = p;
          2: dsel[k] = p + int'($urandom % 5);
          default: dsel[k] = 3 + int'($urandom % (p - 5));
        endcase
      end
      setup(cen, pr, p, dsel[0], dsel[1], dsel[2], dt, 0);
      verify($sformatf("R4 R5 R7 R11 random %0d", it), cen, pr, p,
             dsel[0], dsel[1], dsel[2], dt);
    end

    // R10: stopping the generator
    wr(3'd5, ctrl_word(0, 0, 0, 0, 0));
    @(negedge clk);
    measure(60, hi, lo, rl, ov);
    check_eq("R10 stopped channel cycles", hi[0]+hi[1]+hi[2]+lo[0]+lo[1]+lo[2], 0);
    check_eq("R10 stopped reloads", rl, 0);

    finish_run();
  end
endmodule